// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records execution history into a small on-chip trace store while a debug session is running. A control register picks one of four capture policies: taken branches only, taken branches with back-to-back repeats dropped, every bus access, or the program counter of every executed instruction. It also sets whether the trigger marks the end or the start of the recorded window, and whether tracing is on at all. The core feeds the block event strobes. A debugger writes the control register, pulses `arm` to open a session, and reads the stored entries back once the session is over.

Capture stops in one of two ways. With the trigger at the end, the store keeps the most recent entries and the session closes on the trigger. With the trigger at the start, nothing is stored until the trigger, and the session closes when the store is full. Each stored entry is `{tag[1:0], flag, field_a[W-1:0], field_b[W-1:0]}` (2·W+3 bits).

Top module: `trace_capture`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 (tracing off, taken-branch mode, trigger at end), `armed` is 0 and `rd_vld` is 0.
- R2: Control register layout: bit 0 is trace enable, bits 2:1 are the mode (00 branches, 01 branches without repeats, 10 bus accesses, 11 instruction PCs), bit 3 is the alignment (0 trigger at end, 1 trigger at start), and bits 7:4 read 0. Mode and alignment are written only while `armed` is 0 and can always be read.
- R3: A write changes the trace-enable bit only when both `secure` and `armed` are 0. Otherwise the bit keeps its value.
- R4: In mode 00, each `cof_vld` cycle stores `{2'b01, 0, cof_src, cof_dst}`, and instruction and bus events are not stored.
- R5: In mode 01, a branch whose source and destination both equal those of the last entry stored in this session is dropped. Any other branch is stored as in R4.
- R6: In mode 10, each `bus_vld` cycle stores `{2'b10, bus_wr, bus_addr, bus_data}`, and branch events are not stored.
- R7: In mode 11, each `ins_vld` cycle stores `{2'b11, 0, ins_pc, 0}`.
- R8: With alignment 0, a session stores from `arm` up to and including the trigger cycle, then `armed` falls. If more than DEPTH entries arrive, only the newest DEPTH are kept.
- R9: With alignment 1, events before the trigger are not stored. Storing starts with the trigger cycle, and `armed` falls in the cycle after the DEPTH-th entry is stored. Later events are not stored.
- R10: While disarmed with tracing enabled, each `rd_req` cycle returns the next stored entry, oldest first, on `rd_data`, with `rd_vld` high one cycle later. Requests made beyond the stored count, or while tracing is off, give `rd_vld` 0.
- R11: A session armed with tracing off stores nothing and ends on the trigger in either alignment. Arming clears the stored entries and restarts the read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| secure | input | 1 | System is secured |
| arm | input | 1 | Opens a session when disarmed |
| trig | input | 1 | Trigger event |
| armed | output | 1 | Session in progress |
| cof_vld | input | 1 | Taken branch this cycle |
| cof_src | input | W | Branch source PC |
| cof_dst | input | W | Branch destination PC |
| ins_vld | input | 1 | Instruction executed this cycle |
| ins_pc | input | W | PC of executed instruction |
| bus_vld | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | W | Access address |
| bus_data | input | W | Access data |
| rd_req | input | 1 | Read next trace entry |
| rd_vld | output | 1 | `rd_data` holds a returned entry |
| rd_data | output | 2·W+3 | Returned trace entry |

## Verification
The bench builds the block with W = 8 and DEPTH = 8. The small depth brings wrap-around of the circular store and the fill-triggered end of a trigger-at-start session within a dozen events. The narrow fields keep the expected entries easy to write by hand, while every field position of the entry format is still exercised.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_FLOW = 2'b00,
    MODE_LOOP = 2'b01,
    MODE_BUS  = 2'b10,
    MODE_PC   = 2'b11
  } trc_mode_e;

  typedef enum logic [1:0] {
    SES_IDLE = 2'b00,
    SES_WAIT = 2'b01,
    SES_RUN  = 2'b10
  } trc_ses_e;

  localparam logic [1:0] TAG_FLOW = 2'b01;
  localparam logic [1:0] TAG_BUS  = 2'b10;
  localparam logic [1:0] TAG_PC   = 2'b11;

  typedef struct packed {
    logic      align;
    trc_mode_e mode;
    logic      en;
  } trc_ctl_t;
endpackage

// File: rtl/trc_regs.sv
`timescale 1ns/1ps
module trc_regs
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       secure,
  input  logic       armed,
  output trc_ctl_t   ctl,
  output logic [7:0] rdata
);
  trc_ctl_t ctl_q, ctl_d;
  logic     load;
  logic     unused_hi;

  assign unused_hi = ^wdata[7:4];
  assign load      = wr && !armed;

  always_comb begin
    ctl_d = ctl_q;
    if (load) begin
      ctl_d.mode  = trc_mode_e'(wdata[2:1]);
      ctl_d.align = wdata[3];
      if (!secure) ctl_d.en = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= '0;
    else if (load) ctl_q <= ctl_d;
  end

  assign ctl   = ctl_q;
  assign rdata = {4'b0000, ctl_q};
endmodule

// File: rtl/trc_filter.sv
`timescale 1ns/1ps
module trc_filter
  import trc_pkg::*;
#(
  parameter int W  = 16,
  localparam int EW = 2*W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trc_mode_e     mode,
  input  logic          clr,
  input  logic          store,
  input  logic          cof_vld,
  input  logic [W-1:0]  cof_src,
  input  logic [W-1:0]  cof_dst,
  input  logic          ins_vld,
  input  logic [W-1:0]  ins_pc,
  input  logic          bus_vld,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_addr,
  input  logic [W-1:0]  bus_data,
  output logic          cand_vld,
  output logic [EW-1:0] cand
);
  logic         last_vld_q, last_vld_d;
  logic [W-1:0] last_src_q, last_dst_q;
  logic         last_ld, repeat_hit, flow_mode;

  assign flow_mode  = (mode == MODE_FLOW) || (mode == MODE_LOOP);
  assign repeat_hit = last_vld_q && (cof_src == last_src_q) && (cof_dst == last_dst_q);

  always_comb begin
    cand_vld = 1'b0;
    cand     = {TAG_FLOW, 1'b0, cof_src, cof_dst};
    unique case (mode)
      MODE_FLOW: cand_vld = cof_vld;
      MODE_LOOP: cand_vld = cof_vld && !repeat_hit;
      MODE_BUS: begin
        cand_vld = bus_vld;
        cand     = {TAG_BUS, bus_wr, bus_addr, bus_data};
      end
      MODE_PC: begin
        cand_vld = ins_vld;
        cand     = {TAG_PC, 1'b0, ins_pc, {W{1'b0}}};
      end
      default: cand_vld = 1'b0;
    endcase
  end

  assign last_ld    = clr || (store && flow_mode);
  assign last_vld_d = !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q <= 1'b0;
      last_src_q <= '0;
      last_dst_q <= '0;
    end else if (last_ld) begin
      last_vld_q <= last_vld_d;
      last_src_q <= cof_src;
      last_dst_q <= cof_dst;
    end
  end
endmodule

// File: rtl/trc_buf.sv
`timescale 1ns/1ps
module trc_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int EW = 2*W + 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [EW-1:0] wdata,
  input  logic          rd,
  output logic [CW-1:0] cnt,
  output logic          rd_vld,
  output logic [EW-1:0] rd_data
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rd_addr;
  logic [CW-1:0] cnt_q, cnt_d, ridx_q, ridx_d;
  logic          rd_hit, rd_vld_q;
  logic [EW-1:0] rd_data_q;

  assign rd_hit  = rd && (ridx_q < cnt_q);
  assign rd_addr = wptr_q - cnt_q[AW-1:0] + ridx_q[AW-1:0];

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    ridx_d = ridx_q;
    if (clr) begin
      wptr_d = '0;
      cnt_d  = '0;
      ridx_d = '0;
    end else begin
      if (wr) begin
        wptr_d = wptr_q + 1'b1;
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      end
      if (rd_hit) ridx_d = ridx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      cnt_q     <= '0;
      ridx_q    <= '0;
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      wptr_q   <= wptr_d;
      cnt_q    <= cnt_d;
      ridx_q   <= ridx_d;
      rd_vld_q <= rd_hit;
      if (rd_hit) rd_data_q <= mem[rd_addr];
    end
  end

  assign cnt     = cnt_q;
  assign rd_vld  = rd_vld_q;
  assign rd_data = rd_data_q;
endmodule

// File: rtl/trace_capture.sv
`timescale 1ns/1ps
module trace_capture
  import trc_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int EW = 2*W + 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          secure,
  input  logic          arm,
  input  logic          trig,
  output logic          armed,
  input  logic          cof_vld,
  input  logic [W-1:0]  cof_src,
  input  logic [W-1:0]  cof_dst,
  input  logic          ins_vld,
  input  logic [W-1:0]  ins_pc,
  input  logic          bus_vld,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_addr,
  input  logic [W-1:0]  bus_data,
  input  logic          rd_req,
  output logic          rd_vld,
  output logic [EW-1:0] rd_data
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [1:0]    rsync_q;
  logic          rst_i_n;
  trc_ctl_t      ctl;
  trc_ses_e      st_q, st_d;
  logic          clr, store, cand_vld, rd_ok;
  logic [EW-1:0] cand;
  logic [CW-1:0] buf_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  trc_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .wdata(reg_wdata),
    .secure(secure), .armed(armed), .ctl(ctl), .rdata(reg_rdata)
  );

  trc_filter #(.W(W)) u_filt (
    .clk(clk), .rst_n(rst_i_n), .mode(ctl.mode), .clr(clr), .store(store),
    .cof_vld(cof_vld), .cof_src(cof_src), .cof_dst(cof_dst),
    .ins_vld(ins_vld), .ins_pc(ins_pc),
    .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
    .cand_vld(cand_vld), .cand(cand)
  );

  always_comb begin
    st_d  = st_q;
    clr   = 1'b0;
    store = 1'b0;
    unique case (st_q)
      SES_IDLE: begin
        if (arm) begin
          clr  = 1'b1;
          st_d = (ctl.align && ctl.en) ? SES_WAIT : SES_RUN;
        end
      end
      SES_WAIT: begin
        if (trig) begin
          store = cand_vld;
          st_d  = SES_RUN;
        end
      end
      SES_RUN: begin
        store = ctl.en && cand_vld;
        if (trig && (!ctl.align || !ctl.en))      st_d = SES_IDLE;
        else if (ctl.align && store && buf_cnt == LAST) st_d = SES_IDLE;
      end
      default: st_d = SES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= SES_IDLE;
    else          st_q <= st_d;
  end

  assign armed = (st_q != SES_IDLE);
  assign rd_ok = rd_req && !armed && ctl.en;

  trc_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .wr(store), .wdata(cand),
    .rd(rd_ok), .cnt(buf_cnt), .rd_vld(rd_vld), .rd_data(rd_data)
  );
endmodule

// File: rtl/trc_chk.sv
`timescale 1ns/1ps
module trc_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    reg_rdata,
  input logic          secure,
  input logic          armed,
  input logic          trig,
  input logic          rd_vld,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r2_frozen_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed) |-> $stable(reg_rdata));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'h0);

  a_r3_enable_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> (!$past(secure) && !$past(armed)));

  a_r8_trigger_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reg_rdata[3] && trig) |=> !armed);

  a_r9_never_full_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_rdata[3] && reg_rdata[0]) |-> (cnt < FULL));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  a_r10_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ($past(reg_rdata[0]) && !$past(armed)));

  a_r11_off_stores_none: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reg_rdata[0]) |-> (cnt == '0));
endmodule

bind trace_capture trc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .secure(secure),
  .armed(armed), .trig(trig), .rd_vld(rd_vld), .cnt(buf_cnt)
);

// File: tb/sim_trace_capture.sv
`timescale 1ns/1ps
module sim_trace_capture;
  localparam int W  = 8;
  localparam int D  = 8;
  localparam int EW = 2*W + 3;

  logic          clk, rst_n;
  logic          reg_wr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          secure, arm, trig, armed;
  logic          cof_vld, ins_vld, bus_vld, bus_wr, rd_req, rd_vld;
  logic [W-1:0]  cof_src, cof_dst, ins_pc, bus_addr, bus_data;
  logic [EW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [EW-1:0] exp_q[$];
  string         req_q[$];

  trace_capture #(.W(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .secure(secure), .arm(arm), .trig(trig),
    .armed(armed), .cof_vld(cof_vld), .cof_src(cof_src), .cof_dst(cof_dst),
    .ins_vld(ins_vld), .ins_pc(ins_pc), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data), .rd_req(rd_req),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] ent(input logic [1:0] tag, input logic f,
                                        input logic [W-1:0] a, input logic [W-1:0] b);
    return {tag, f, a, b};
  endfunction

  task automatic push(input logic [EW-1:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  // monitor: pop and compare each returned entry
  always @(posedge clk) begin
    #1;
    if (rd_vld === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected entry", rd_data, 0);
      else begin
        logic [EW-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(rd_data == e, r, rd_data, e);
      end
    end
  end

  task automatic wreg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic ev_cof(input logic [W-1:0] s, input logic [W-1:0] d, input logic t);
    @(negedge clk); cof_vld = 1'b1; cof_src = s; cof_dst = d; trig = t;
    @(negedge clk); cof_vld = 1'b0; trig = 1'b0;
  endtask

  task automatic ev_bus(input logic [W-1:0] a, input logic [W-1:0] d, input logic w);
    @(negedge clk); bus_vld = 1'b1; bus_addr = a; bus_data = d; bus_wr = w;
    @(negedge clk); bus_vld = 1'b0;
  endtask

  task automatic ev_ins(input logic [W-1:0] pc);
    @(negedge clk); ins_vld = 1'b1; ins_pc = pc;
    @(negedge clk); ins_vld = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic read_n(input int n);
    @(negedge clk); rd_req = 1'b1;
    repeat (n) @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all expected entries returned", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_wdata = 0; secure = 0; arm = 0; trig = 0;
    cof_vld = 0; cof_src = 0; cof_dst = 0; ins_vld = 0; ins_pc = 0;
    bus_vld = 0; bus_wr = 0; bus_addr = 0; bus_data = 0; rd_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 8'h00, "R1 register reset", reg_rdata, 0);
    chk(armed == 1'b0, "R1 armed reset", armed, 0);
    chk(rd_vld == 1'b0, "R1 rd_vld reset", rd_vld, 0);

    // R2 / R3: secure blocks enable, mode and align still written, upper bits 0
    secure = 1'b1;
    wreg(8'hFF);
    chk(reg_rdata == 8'h0E, "R3 enable blocked by secure", reg_rdata, 8'h0E);
    secure = 1'b0;
    wreg(8'h01);
    chk(reg_rdata == 8'h01, "R2 write while disarmed", reg_rdata, 8'h01);

    // R4 taken-branch mode
    do_arm();
    chk(armed == 1'b1, "R8 armed after arm", armed, 1);
    wreg(8'h0E);
    chk(reg_rdata == 8'h01, "R2 R3 write ignored while armed", reg_rdata, 8'h01);
    ev_cof(8'h01, 8'h02, 0); push(ent(2'b01, 0, 8'h01, 8'h02), "R4 branch 1");
    ev_bus(8'h10, 8'h11, 1);
    ev_ins(8'h20);
    ev_cof(8'h03, 8'h04, 0); push(ent(2'b01, 0, 8'h03, 8'h04), "R4 branch 2");
    ev_cof(8'h03, 8'h04, 0); push(ent(2'b01, 0, 8'h03, 8'h04), "R4 repeat kept");
    ev_cof(8'h05, 8'h06, 1); push(ent(2'b01, 0, 8'h05, 8'h06), "R8 trigger cycle stored");
    chk(armed == 1'b0, "R8 trigger disarms", armed, 0);
    read_n(6);

    // R5 repeat suppression
    wreg(8'h03);
    do_arm();
    ev_cof(8'h11, 8'h11, 0); push(ent(2'b01, 0, 8'h11, 8'h11), "R5 first");
    ev_cof(8'h11, 8'h11, 0);
    ev_cof(8'h22, 8'h22, 0); push(ent(2'b01, 0, 8'h22, 8'h22), "R5 new");
    ev_cof(8'h11, 8'h11, 0); push(ent(2'b01, 0, 8'h11, 8'h11), "R5 non-adjacent kept");
    ev_cof(8'h11, 8'h11, 0);
    pulse_trig();
    read_n(5);

    // R6 bus mode
    wreg(8'h05);
    do_arm();
    ev_cof(8'h33, 8'h34, 0);
    ev_bus(8'h0A, 8'h14, 1); push(ent(2'b10, 1, 8'h0A, 8'h14), "R6 write access");
    ev_bus(8'h0B, 8'h15, 0); push(ent(2'b10, 0, 8'h0B, 8'h15), "R6 read access");
    pulse_trig();
    read_n(4);

    // R7 instruction PC mode
    wreg(8'h07);
    do_arm();
    ev_cof(8'h40, 8'h41, 0);
    ev_ins(8'h30); push(ent(2'b11, 0, 8'h30, 8'h00), "R7 pc 1");
    ev_ins(8'h31); push(ent(2'b11, 0, 8'h31, 8'h00), "R7 pc 2");
    pulse_trig();
    read_n(4);

    // R8 wrap-around keeps newest D
    wreg(8'h01);
    do_arm();
    for (int i = 0; i < 12; i++) begin
      ev_cof(W'(i), W'(i + 100), 0);
      if (i >= 12 - D) push(ent(2'b01, 0, W'(i), W'(i + 100)), "R8 wrap newest kept");
    end
    pulse_trig();
    read_n(D + 2);

    // R9 trigger at start, ends on fill
    wreg(8'h09);
    do_arm();
    ev_cof(8'h50, 8'h51, 0);
    for (int k = 0; k < 10; k++) begin
      ev_cof(W'(8'h60 + k), W'(8'h70 + k), k == 0);
      if (k < D) push(ent(2'b01, 0, W'(8'h60 + k), W'(8'h70 + k)), "R9 post-trigger entry");
      if (k == 0) chk(armed == 1'b1, "R9 armed after trigger", armed, 1);
    end
    chk(armed == 1'b0, "R9 disarmed on fill", armed, 0);

    // R10 read blocked while tracing off
    wreg(8'h08);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(posedge clk); #1;
    chk(rd_vld == 1'b0, "R10 no read when disabled", rd_vld, 0);
    wreg(8'h09);
    read_n(D + 1);

    // R11 session with tracing off
    wreg(8'h08);
    do_arm();
    ev_cof(8'h01, 8'h02, 0);
    ev_cof(8'h03, 8'h04, 1);
    chk(armed == 1'b0, "R11 trigger ends disabled session", armed, 0);
    wreg(8'h01);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(posedge clk); #1;
    chk(rd_vld == 1'b0, "R11 nothing stored and store cleared", rd_vld, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule